// File: doc/BRIEF.md
# Slow-Domain Register Port with Divider-Paced Completion

This block is an APB completer whose register bank is updated only in a slow time base. The slow time base is a clock enable taken from a free-running divider on the bus clock. A read or a write therefore cannot finish on an arbitrary bus cycle. It finishes only on the cycle that carries a slow-enable pulse, and that is the same cycle on which the register bank takes its update.

The completer holds the ready output low for each access-phase cycle that comes before the next pulse. On the pulse cycle it raises ready for one cycle. In that same cycle a write is committed and read data is driven. The number of wait states is therefore not fixed. It depends on where the access phase starts within the divider period, and it lies anywhere from zero to one less than the divide ratio.

The bus side is the plain APB request/completion handshake. The ready output is the only back-pressure: the requester keeps its select, enable, address and data stable until it sees ready high at a clock edge.

Top module: `apb_slowreg_slave`

## Requirements
- R1: While `presetn` is low, and after any reset, `pready` is 0 and `prdata` is 0. Every register reads as zero until it is written.
- R2: The divider raises an internal one-cycle enable pulse once every DIV bus cycles (DIV ≥ 2, default 4). Counting the first rising edge after reset release as edge 1, the cycle that follows edge n carries a pulse exactly when n mod DIV equals DIV−1.
- R3: `pready` is 1 only in an access-phase cycle (`psel` and `penable` both 1) that was preceded by a setup cycle (`psel` 1, `penable` 0). It is 1 on exactly one cycle per transfer, and it is never 1 on two cycles in a row.
- R4: `pready` rises on the first access-phase cycle that carries an enable pulse. The wait count is 0 when the access phase begins on a pulse cycle, and it never exceeds DIV−1.
- R5: A write to a mapped register is committed at the clock edge that ends its `pready` cycle. A read that starts later returns the new value.
- R6: During the `pready` cycle of a read, `prdata` holds the addressed register's current value. In every cycle where `pready` is 0, `prdata` is 0.
- R7: An address is mapped when `paddr[1:0]` is 0 and `paddr[AW-1:2]` is below NREG. Register k sits at byte address 4·k. Accesses to unmapped addresses follow the same wait rule. Such a read returns 0, and such a write changes no register.
- R8: With the default DIV of 4, a sweep of the access start over all phases yields wait counts of both 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock; also drives the divider |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address |
| pwdata | input | DW | Write data |
| pready | output | 1 | Completion, high for one cycle on a slow-enable tick |
| prdata | output | DW | Read data, valid only while pready is high |

## Verification
Two things can fall on the same bus cycle: the divider's enable pulse and the first cycle of an access phase. When they do, the transfer finishes with no wait state, and the write commit or read return happens in the cycle the access phase begins. The bench provokes this by putting 0 to DIV−1 idle cycles between transfers, so that each setup phase lands on a different divider phase. A behavioural model counts edges since reset, predicts the pulse, and judges `pready` and `prdata` on every cycle. Each transfer's wait count is also compared with the distance to the next predicted pulse.

// File: rtl/apbdiv_pkg.sv
package apbdiv_pkg;
  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_ACCESS = 1'b1
  } apb_phase_e;
endpackage

// File: rtl/div_tick_gen.sv
module div_tick_gen #(
  parameter int DIV = 4
) (
  input  logic pclk,
  input  logic presetn,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)           phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == LAST);

  // R2
  tick_gap_chk: assert property (@(posedge pclk) disable iff (!presetn)
    tick |=> !tick);
endmodule

// File: rtl/apb_wait_ctl.sv
module apb_wait_ctl
  import apbdiv_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic pclk,
  input  logic presetn,
  input  logic psel,
  input  logic penable,
  input  logic tick,
  output logic pready
);
  localparam int WCW = $clog2(DIV + 1) + 1;

  apb_phase_e ph_q, ph_d;

  always_comb begin
    ph_d = PH_IDLE;
    if (psel && !penable)
      ph_d = PH_ACCESS;
    else if (ph_q == PH_ACCESS && psel && penable && !tick)
      ph_d = PH_ACCESS;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) ph_q <= PH_IDLE;
    else          ph_q <= ph_d;
  end

  assign pready = (ph_q == PH_ACCESS) && psel && penable && tick;

  // Checker: consecutive stalled access cycles
  logic [WCW-1:0] stall_q;
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) stall_q <= '0;
    else if (psel && penable && !pready) stall_q <= stall_q + 1'b1;
    else stall_q <= '0;
  end

  // R3
  ready_in_access_chk: assert property (@(posedge pclk) disable iff (!presetn)
    pready |-> (psel && penable));
  // R3
  ready_single_chk: assert property (@(posedge pclk) disable iff (!presetn)
    pready |=> !pready);
  // R4
  wait_bound_chk: assert property (@(posedge pclk) disable iff (!presetn)
    int'(stall_q) < DIV);
endmodule

// File: rtl/slow_regbank.sv
module slow_regbank #(
  parameter int NREG = 4,
  parameter int DW   = 32,
  parameter int IW   = 2
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (idx == IW'(i)) regs_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == IW'(i)) rdata = regs_q[i];
  end
endmodule

// File: rtl/apb_slowreg_slave.sv
module apb_slowreg_slave #(
  parameter int DIV  = 4,
  parameter int NREG = 4,
  parameter int DW   = 32,
  parameter int AW   = 8
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic          pready,
  output logic [DW-1:0] prdata
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic          tick_w;
  logic          hit;
  logic          wr_en;
  logic [IW-1:0] idx;
  logic [DW-1:0] bank_rdata;
  logic [AW-3:0] word;

  assign word = paddr[AW-1:2];
  assign hit  = (paddr[1:0] == 2'b00) && (int'(word) < NREG);
  assign idx  = word[IW-1:0];

  div_tick_gen #(.DIV(DIV)) u_div (
    .pclk(pclk), .presetn(presetn), .tick(tick_w)
  );

  apb_wait_ctl #(.DIV(DIV)) u_wait (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .tick(tick_w), .pready(pready)
  );

  assign wr_en = pready && pwrite && hit;

  slow_regbank #(.NREG(NREG), .DW(DW), .IW(IW)) u_bank (
    .pclk(pclk), .presetn(presetn), .wr_en(wr_en), .idx(idx),
    .wdata(pwdata), .rdata(bank_rdata)
  );

  assign prdata = (pready && !pwrite && hit) ? bank_rdata : '0;

  // R5
  write_on_tick_chk: assert property (@(posedge pclk) disable iff (!presetn)
    wr_en |-> tick_w);
  // R6
  data_with_ready_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (prdata != '0) |-> pready);
endmodule

// File: tb/test_apb_slowreg_slave.sv
module test_apb_slowreg_slave;
  localparam int DIV = 4, NREG = 4, DW = 32, AW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstn, psel, penable, pwrite, pready;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata, prdata;

  apb_slowreg_slave #(.DIV(DIV), .NREG(NREG), .DW(DW), .AW(AW)) i_apb_slowreg_slave (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pready(pready), .prdata(prdata)
  );

  int n_cmp = 0, n_bad = 0;
  int ncyc = 0;
  bit armed = 0;
  logic [DW-1:0] mdl [NREG];
  int wmin = 1000, wmax = -1;

  function automatic bit mapped(logic [AW-1:0] a);
    return (a[1:0] == 2'b00) && (int'(a[AW-1:2]) < NREG);
  endfunction

  function automatic bit exp_ready();
    return armed && psel && penable && ((ncyc % DIV) == DIV - 1);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: edge counter, phase flag, register image (R2, R5)
  always @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      ncyc = 0; armed = 0;
      for (int i = 0; i < NREG; i++) mdl[i] = '0;
    end else begin
      bit done;
      done = exp_ready();
      if (done && pwrite && mapped(paddr)) mdl[paddr[AW-1:2]] = pwdata;
      armed = (psel && !penable) || (armed && psel && penable && !done);
      ncyc = ncyc + 1;
    end
  end

  // Per-cycle comparison (R1, R3, R6)
  always @(negedge clk) begin
    logic [DW-1:0] ed;
    if (!rstn) begin
      chk(pready == 1'b0, "R1 pready in reset", pready, 0);
      chk(prdata == '0, "R1 prdata in reset", prdata, 0);
    end else begin
      ed = (exp_ready() && !pwrite && mapped(paddr)) ? mdl[paddr[AW-1:2]] : '0;
      chk(pready == exp_ready(), "R3 pready", pready, exp_ready());
      chk(prdata == ed, "R6 prdata", prdata, ed);
    end
  end

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd);
    int w, ew;
    @(posedge clk); #1 psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk); #1 penable = 1;
    @(negedge clk);
    ew = (DIV - 1) - (ncyc % DIV);
    w = 0;
    while (!pready && w < 4 * DIV) begin w++; @(negedge clk); end
    rd = prdata;
    chk(w == ew, "R4 wait count", w, ew);
    if (w < wmin) wmin = w;
    if (w > wmax) wmax = w;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic gap(int g);
    repeat (g) @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    rstn = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    repeat (4) @(negedge clk);
    rstn = 1;

    // R1: registers read zero after reset; R2: first pulse timing via wait count
    for (int k = 0; k < NREG; k++) begin
      xfer(0, AW'(4 * k), '0, rd);
      chk(rd == '0, "R1 reset readback", rd, 0);
    end

    // R5/R6 with phase sweep (R4, R8)
    for (int rep = 0; rep < 3; rep++)
      for (int k = 0; k < NREG; k++) begin
        logic [DW-1:0] v;
        v = 32'hA5000000 ^ (rep << 12) ^ (k * 32'h01010101) ^ 32'h5A;
        gap((k + rep) % DIV);
        xfer(1, AW'(4 * k), v, rd);
        gap((k + 2 * rep + 1) % DIV);
        xfer(0, AW'(4 * k), '0, rd);
        chk(rd == v, "R5 write then read", rd, v);
      end

    // R7: unmapped writes and reads
    xfer(1, AW'(4 * NREG), 32'hDEADBEEF, rd);
    gap(1);
    xfer(1, AW'(1), 32'hCAFEF00D, rd);
    gap(2);
    xfer(1, 8'hFC, 32'h12345678, rd);
    xfer(0, AW'(4 * NREG), '0, rd);
    chk(rd == '0, "R7 unmapped read", rd, 0);
    gap(3);
    xfer(0, AW'(2), '0, rd);
    chk(rd == '0, "R7 misaligned read", rd, 0);
    for (int k = 0; k < NREG; k++) begin
      gap(k);
      xfer(0, AW'(4 * k), '0, rd);
      chk(rd == mdl[k], "R7 mapped unchanged", rd, mdl[k]);
    end

    // R8: both extremes of wait count seen with default divide ratio
    chk(wmin == 0, "R8 min wait", wmin, 0);
    chk(wmax == DIV - 1, "R8 max wait", wmax, DIV - 1);

    // R1: reset in mid-stream clears the bank
    @(posedge clk); #1 rstn = 0;
    repeat (2) @(negedge clk);
    rstn = 1;
    xfer(0, AW'(0), '0, rd);
    chk(rd == '0, "R1 post-reset read", rd, 0);

    gap(2);
    summary();
    $finish;
  end
endmodule